// File: doc/BRIEF.md
# Stepper Two-Bit Gray Sequencer

This block produces the two-phase drive pattern for a stepper motor. Two output pins carry a 2-bit Gray code, so exactly one pin changes on each step. A free-running period counter, clocked by the system clock, sets the pace. It counts up from zero, and when it reaches the programmed period value it fires one step and starts again from zero. A step therefore occurs every `period + 1` clock cycles.

The direction input picks the order in which the Gray states are walked, forward or reverse. A direction change applies to the next step and keeps the current phase. Stepping happens only while the waveform-mode input is high. With that input low, the counter and the phase both freeze where they are. When the enable input is low, the outputs go to 00 and the counter goes back to zero.

The asynchronous active-low reset takes effect at once. Its release is synchronised to the clock inside the block.

Top module: `stepper_gray_seq`

## Requirements
- R1: After reset the outputs `{phase_b, phase_a}` are 00, and they stay 00 while `enable` is low.
- R2: A clock edge that samples `enable` low sets the outputs to 00 and clears the period counter. After `enable` rises again, the first step falls `period + 1` edges after the first enabled edge.
- R3: With `dir_down` = 0, successive steps drive `{phase_b, phase_a}` through 00 → 01 → 11 → 10 → 00, repeating.
- R4: With `dir_down` = 1, successive steps drive `{phase_b, phase_a}` through 00 → 10 → 11 → 01 → 00, repeating.
- R5: While enabled and in waveform mode, the counter advances on every edge, and a step occurs on each edge where the count is at or above `period`. A step happens every `period + 1` cycles, and every cycle when `period` = 0.
- R6: While `wave_mode` is low and `enable` is high, the outputs and the period count hold. Stepping resumes from the held count once `wave_mode` returns high.
- R7: A change of `dir_down` applies from the next step onward. It does not reset the current Gray state or the count.
- R8: Each step while enabled changes exactly one of the two outputs.
- R9: If `period` is lowered below the current count, a step occurs at the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Sequencer enable; low forces outputs to 00 and clears the counter |
| dir_down | input | 1 | 0 = forward Gray order, 1 = reverse Gray order |
| wave_mode | input | 1 | Waveform mode; low freezes counter and phase |
| period | input | PERIOD_W | Terminal count of the step period counter |
| phase_a | output | 1 | Gray code bit 0 |
| phase_b | output | 1 | Gray code bit 1 |

## Verification
The outputs come straight from a register, so any input sampled at an edge shows up on the pins after that same edge, one register stage later. A change in `enable`, `wave_mode`, `dir_down` or `period` therefore reaches the pins exactly one edge after it is applied. The bench drives its inputs and samples the pins on the falling edge. A behavioural model, built from a step counter and a phase index, updates on each rising edge, and the pins are compared against it half a cycle later, on every clock. This means a step that arrives a cycle early or late is reported in the very cycle it goes wrong.

// File: rtl/stepper_gray_pkg.sv
package stepper_gray_pkg;

  typedef logic [1:0] phase_idx_t;

  // Binary phase index to the 2-bit reflected code seen on the pins.
  function automatic logic [1:0] idx_to_gray(input phase_idx_t idx);
    return idx ^ (idx >> 1);
  endfunction

endpackage

// File: rtl/stepper_rst_sync.sv
module stepper_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/stepper_period_cnt.sv
module stepper_period_cnt #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                run_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                step_o
);

  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] cnt_d;
  logic                cnt_en;
  logic                hit;

  assign hit    = (cnt_q >= period_i);
  assign step_o = run_i && !clr_i && hit;
  assign cnt_en = clr_i || run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (run_i) begin
      cnt_d = hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !run_i) |=> $stable(cnt_q));

  // R5
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> (cnt_q == '0));

endmodule

// File: rtl/stepper_phase_gen.sv
module stepper_phase_gen
  import stepper_gray_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       step_i,
  input  logic       down_i,
  output logic [1:0] gray_o
);

  phase_idx_t idx_q;
  phase_idx_t idx_d;
  logic       idx_en;

  assign idx_en = clr_i || step_i;

  always_comb begin
    idx_d = idx_q;
    if (clr_i) begin
      idx_d = '0;
    end else if (step_i) begin
      idx_d = down_i ? idx_q - 1'b1 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign gray_o = idx_to_gray(idx_q);

  // R8
  one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i) |=> ($countones(gray_o ^ $past(gray_o)) == 1));

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(gray_o));

  // R2
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (gray_o == 2'b00));

endmodule

// File: rtl/stepper_gray_seq.sv
module stepper_gray_seq #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                dir_down,
  input  logic                wave_mode,
  input  logic [PERIOD_W-1:0] period,
  output logic                phase_a,
  output logic                phase_b
);

  logic       rst_sync_n;
  logic       clr;
  logic       step;
  logic [1:0] gray;

  assign clr = !enable;

  stepper_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stepper_period_cnt #(.PERIOD_W(PERIOD_W)) u_period_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_i    (clr),
    .run_i    (wave_mode),
    .period_i (period),
    .step_o   (step)
  );

  stepper_phase_gen u_phase_gen (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (clr),
    .step_i (step),
    .down_i (dir_down),
    .gray_o (gray)
  );

  assign phase_a = gray[0];
  assign phase_b = gray[1];

  // R1
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enable |=> ({phase_b, phase_a} == 2'b00));

  // R6
  wave_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enable && !wave_mode) |=> ($stable(phase_a) && $stable(phase_b)));

endmodule

// File: tb/stepper_gray_seq_bench.sv
module stepper_gray_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PW         = 16;
  localparam int MAX_CYCLES = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          dir_down = 1'b0;
  logic          wave_mode = 1'b0;
  logic [PW-1:0] period = '0;
  logic          phase_a;
  logic          phase_b;

  int tests  = 0;
  int fails  = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Reference model state
  int m_cnt = 0;
  int m_idx = 0;
  int seq_up[4] = '{0, 1, 3, 2};
  logic [1:0] prev_out = 2'b00;
  bit prev_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepper_gray_seq #(.PERIOD_W(PW)) u_stepper_gray_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .dir_down  (dir_down),
    .wave_mode (wave_mode),
    .period    (period),
    .phase_a   (phase_a),
    .phase_b   (phase_b)
  );

  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      m_cnt = 0;
      m_idx = 0;
    end else if (wave_mode) begin
      if (m_cnt >= int'(period)) begin
        m_cnt = 0;
        m_idx = dir_down ? (m_idx + 3) % 4 : (m_idx + 1) % 4;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model plus the one-bit step rule (R8)
  always @(negedge clk) begin
    logic [1:0] out_now;
    out_now = {phase_b, phase_a};
    if (checking) begin
      check(cur_req, out_now, 2'(seq_up[m_idx]));
      if (prev_en && enable && out_now != prev_out) begin
        tests++;
        if ($countones(out_now ^ prev_out) != 1) begin
          fails++;
          $display("FAIL R8: step %b -> %b expected one bit change", prev_out, out_now);
        end
      end
    end
    prev_out = out_now;
    prev_en  = enable;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    // R1: reset state
    check("R1", {phase_b, phase_a}, 2'b00);
    checking = 1'b1;
    cur_req = "R1";
    cycles(3);

    // R3: forward order, period 3
    cur_req = "R3"; period = 16'd3; wave_mode = 1'b1; enable = 1'b1;
    cycles(4);
    check("R3", {phase_b, phase_a}, 2'b01);
    cycles(4);
    check("R3", {phase_b, phase_a}, 2'b11);
    cycles(4);
    check("R3", {phase_b, phase_a}, 2'b10);
    cycles(4);
    check("R3", {phase_b, phase_a}, 2'b00);
    cycles(20);

    // R5: period 0 steps every clock, then period 5
    cur_req = "R5"; period = 16'd0;
    cycles(12);
    period = 16'd5;
    cycles(30);

    // R7: direction flip mid-run
    cur_req = "R7"; period = 16'd2;
    cycles(7);
    dir_down = 1'b1;
    cycles(8);
    dir_down = 1'b0;
    cycles(5);

    // R4: reverse order from a clean start
    cur_req = "R4"; enable = 1'b0; dir_down = 1'b1;
    cycles(1);
    enable = 1'b1; period = 16'd1;
    cycles(2);
    check("R4", {phase_b, phase_a}, 2'b10);
    cycles(2);
    check("R4", {phase_b, phase_a}, 2'b11);
    cycles(2);
    check("R4", {phase_b, phase_a}, 2'b01);
    cycles(2);
    check("R4", {phase_b, phase_a}, 2'b00);
    cycles(10);

    // R6: waveform mode off holds, then resumes
    cur_req = "R6"; dir_down = 1'b0; period = 16'd4;
    cycles(6);
    wave_mode = 1'b0;
    cycles(12);
    wave_mode = 1'b1;
    cycles(15);

    // R9: lowering period below current count
    cur_req = "R9"; period = 16'd20;
    cycles(10);
    period = 16'd2;
    cycles(12);

    // R2: disable clears outputs and counter
    cur_req = "R2"; period = 16'd4;
    cycles(3);
    enable = 1'b0;
    cycles(1);
    check("R2", {phase_b, phase_a}, 2'b00);
    cycles(4);
    enable = 1'b1;
    cycles(4);
    check("R2", {phase_b, phase_a}, 2'b00);
    cycles(1);
    check("R2", {phase_b, phase_a}, 2'b01);
    cycles(20);

    checking = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule